// File: doc/BRIEF.md
# Parallel Port Enhanced Address/Data Cycle Engine

This block turns host I/O accesses to the upper five offsets of a parallel port window into enhanced-mode address and data transfers on an 8-bit peripheral bus. A host write or read at the address offset runs a transfer that uses the address strobe. A host access at any of the four data offsets runs a transfer that uses the data strobe. The four data offsets behave the same way and share one data register. Each transfer asserts its strobe and waits for the peripheral's wait input to go active. It then releases the strobe and waits for wait to go inactive. A busy output holds off the host for the whole handshake.

Write data passes straight through onto the bus while the host write strobe is high. The value seen at the trailing edge of that strobe is kept in the address or data register. Read data is sampled from the bus in the clock where the peripheral strobe is released, and it is held for the rest of the host read. While no transfer is running, the bus and the control pins fall back to standard/bidirectional behaviour taken from the control register inputs. The block only responds when enhanced mode is enabled.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset, busy is 0, the address and data registers both read 0, and the control pins show the idle fallback values.
- R2: A host access at offset 3 runs a transfer that drives astb_n low and leaves dstb_n high.
- R3: Host accesses at offsets 4, 5, 6 and 7 each run a transfer that drives dstb_n low and leaves astb_n high. All four offsets read and write one shared data register.
- R4: During a write transfer, pd_oe is 1, write_n is 0 until the host drops its write strobe, and pd_out equals the host data without inversion.
- R5: A write stores the host data present at the trailing edge of host_wr. Data changed with or after that edge is not stored.
- R6: A read stores pd_in as sampled in the clock where the strobe is released. host_rdata keeps that value after pd_in changes.
- R7: The strobe stays low until periph_wait is seen high. busy then stays high until periph_wait is seen low again.
- R8: With epp_en low, or at offsets 0 to 2, a host access starts no transfer and leaves both registers unchanged.
- R9: With no transfer running, write_n = ~ctl_strobe, dstb_n = ~ctl_autofd, astb_n = ~ctl_selin, init_n = ~ctl_init, pd_oe = ~ctl_dir and pd_out = spp_data.
- R10: During a read transfer, write_n is 1 and pd_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| epp_en | input | 1 | Enhanced mode selected |
| host_addr | input | 3 | Host offset within the port window |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, active high |
| host_rd | input | 1 | Host read strobe, active high |
| host_rdata | output | 8 | Register selected by host_addr (0 outside offsets 3 to 7) |
| host_busy | output | 1 | Handshake in progress, host must wait |
| ctl_strobe | input | 1 | Control register strobe bit |
| ctl_autofd | input | 1 | Control register autofeed bit |
| ctl_selin | input | 1 | Control register select-in bit |
| ctl_init | input | 1 | Control register init bit |
| ctl_dir | input | 1 | Control register direction bit (1 = input) |
| spp_data | input | 8 | Standard-mode data register value |
| pd_out | output | 8 | Peripheral bus output value |
| pd_in | input | 8 | Peripheral bus input value |
| pd_oe | output | 1 | Peripheral bus output enable |
| write_n | output | 1 | Write line (low = write transfer) |
| dstb_n | output | 1 | Data strobe, active low |
| astb_n | output | 1 | Address strobe, active low |
| init_n | output | 1 | Init pin, active low |
| periph_wait | input | 1 | Peripheral wait handshake |

## Verification
The assertions assume a well-behaved peripheral: it raises periph_wait only while a strobe is low, keeps it high until the strobe is released, and then drops it. They also assume the host holds its strobe until busy falls. The bench models the peripheral as a counter that raises wait a set number of cycles after a strobe falls and clears it one cycle after the strobe rises. The host tasks only drop their strobe after busy has gone low. The control register inputs stay at zero whenever a transfer runs, so the fallback pin values never change during a handshake.

// File: rtl/epp_pkg.sv
package epp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_STROBE  = 2'd1,
      ST_RELEASE = 2'd2,
      ST_DONE    = 2'd3
   } epp_state_e;

   typedef struct packed {
      logic is_addr;
      logic is_write;
   } epp_kind_t;
endpackage

// File: rtl/epp_host_decode.sv
module epp_host_decode #(
   parameter int OFS_W       = 3,
   parameter int ADDR_OFS    = 3,
   parameter int DATA_OFS_LO = 4,
   parameter int DATA_OFS_HI = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             epp_en,
   input  logic [OFS_W-1:0] host_addr,
   input  logic             host_wr,
   input  logic             host_rd,
   output logic             hit_addr,
   output logic             hit_data,
   output logic             wr_rise,
   output logic             rd_rise,
   output logic             wr_fall
);
   localparam logic [OFS_W-1:0] A_OFS  = OFS_W'(ADDR_OFS);
   localparam logic [OFS_W-1:0] D_LO   = OFS_W'(DATA_OFS_LO);
   localparam logic [OFS_W-1:0] D_HI   = OFS_W'(DATA_OFS_HI);

   logic wr_q, rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q <= 1'b0;
         rd_q <= 1'b0;
      end else begin
         wr_q <= host_wr;
         rd_q <= host_rd;
      end
   end

   assign hit_addr = epp_en && (host_addr == A_OFS);
   assign hit_data = epp_en && (host_addr >= D_LO) && (host_addr <= D_HI);
   assign wr_rise  = host_wr && !wr_q;
   assign rd_rise  = host_rd && !rd_q;
   assign wr_fall  = !host_wr && wr_q;
endmodule

// File: rtl/epp_handshake_fsm.sv
module epp_handshake_fsm
   import epp_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  epp_kind_t  start_kind,
   input  logic       periph_wait,
   input  logic       host_strobe,
   output epp_state_e state,
   output epp_kind_t  kind,
   output logic       release_evt,
   output logic       busy
);
   logic wait_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign wait_s = periph_wait;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh <= '0;
         end else begin
            sh[0] <= periph_wait;
            for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
         end
      end
      assign wait_s = sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         kind  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_STROBE;
               kind  <= start_kind;
            end
            ST_STROBE:  if (wait_s) state <= ST_RELEASE;
            ST_RELEASE: if (!wait_s) state <= ST_DONE;
            ST_DONE:    if (!host_strobe) state <= ST_IDLE;
            default:    state <= ST_IDLE;
         endcase
      end
   end

   assign release_evt = (state == ST_STROBE) && wait_s;
   assign busy        = (state == ST_STROBE) || (state == ST_RELEASE);
endmodule

// File: rtl/epp_port_regs.sv
module epp_port_regs
   import epp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] pd_in,
   input  epp_kind_t         kind,
   input  logic              rd_capture,
   input  logic              wr_commit,
   output logic [DATA_W-1:0] hold_q,
   output logic [DATA_W-1:0] addr_reg,
   output logic [DATA_W-1:0] data_reg
);
   logic [DATA_W-1:0] next_val;
   logic              load;

   assign load     = rd_capture || wr_commit;
   assign next_val = wr_commit ? hold_q : pd_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q   <= '0;
         addr_reg <= '0;
         data_reg <= '0;
      end else begin
         if (host_wr) hold_q <= host_wdata;
         if (load && kind.is_addr)  addr_reg <= next_val;
         if (load && !kind.is_addr) data_reg <= next_val;
      end
   end
endmodule

// File: rtl/epp_pin_mux.sv
module epp_pin_mux
   import epp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              in_cycle,
   input  logic              strobe_on,
   input  epp_kind_t         kind,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] hold_q,
   input  logic              ctl_strobe,
   input  logic              ctl_autofd,
   input  logic              ctl_selin,
   input  logic              ctl_init,
   input  logic              ctl_dir,
   input  logic [DATA_W-1:0] spp_data,
   output logic [DATA_W-1:0] pd_out,
   output logic              pd_oe,
   output logic              write_n,
   output logic              dstb_n,
   output logic              astb_n,
   output logic              init_n
);
   always_comb begin
      init_n = !ctl_init;
      if (in_cycle) begin
         write_n = !kind.is_write;
         astb_n  = !(strobe_on && kind.is_addr);
         dstb_n  = !(strobe_on && !kind.is_addr);
         pd_oe   = kind.is_write;
         if (kind.is_write) pd_out = host_wr ? host_wdata : hold_q;
         else               pd_out = spp_data;
      end else begin
         write_n = !ctl_strobe;
         dstb_n  = !ctl_autofd;
         astb_n  = !ctl_selin;
         pd_oe   = !ctl_dir;
         pd_out  = spp_data;
      end
   end
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
   import epp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OFS_W       = 3,
   parameter int ADDR_OFS    = 3,
   parameter int DATA_OFS_LO = 4,
   parameter int DATA_OFS_HI = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              epp_en,
   input  logic [OFS_W-1:0]  host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_wr,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_busy,
   input  logic              ctl_strobe,
   input  logic              ctl_autofd,
   input  logic              ctl_selin,
   input  logic              ctl_init,
   input  logic              ctl_dir,
   input  logic [DATA_W-1:0] spp_data,
   output logic [DATA_W-1:0] pd_out,
   input  logic [DATA_W-1:0] pd_in,
   output logic              pd_oe,
   output logic              write_n,
   output logic              dstb_n,
   output logic              astb_n,
   output logic              init_n,
   input  logic              periph_wait
);
   localparam int OFS_SPAN = 1 << OFS_W;

   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (!(ADDR_OFS < DATA_OFS_LO && DATA_OFS_LO <= DATA_OFS_HI && DATA_OFS_HI < OFS_SPAN)) begin : g_bad_map
      $error("offset map must be address, then data range, inside the window");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 to 4");
   end

   logic       hit_addr, hit_data, wr_rise, rd_rise, wr_fall;
   logic       start, release_evt, in_cycle, strobe_on;
   epp_kind_t  start_kind, kind;
   epp_state_e state;
   logic [DATA_W-1:0] hold_q, addr_reg, data_reg;

   epp_host_decode #(
      .OFS_W(OFS_W), .ADDR_OFS(ADDR_OFS),
      .DATA_OFS_LO(DATA_OFS_LO), .DATA_OFS_HI(DATA_OFS_HI)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .epp_en(epp_en), .host_addr(host_addr),
      .host_wr(host_wr), .host_rd(host_rd),
      .hit_addr(hit_addr), .hit_data(hit_data),
      .wr_rise(wr_rise), .rd_rise(rd_rise), .wr_fall(wr_fall)
   );

   assign start               = (wr_rise || rd_rise) && (hit_addr || hit_data);
   assign start_kind.is_addr  = hit_addr;
   assign start_kind.is_write = wr_rise;

   epp_handshake_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .start_kind(start_kind),
      .periph_wait(periph_wait), .host_strobe(host_wr || host_rd),
      .state(state), .kind(kind), .release_evt(release_evt), .busy(host_busy)
   );

   assign in_cycle  = (state != ST_IDLE);
   assign strobe_on = (state == ST_STROBE);

   epp_port_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .pd_in(pd_in), .kind(kind),
      .rd_capture(release_evt && !kind.is_write),
      .wr_commit((state == ST_DONE) && kind.is_write && wr_fall),
      .hold_q(hold_q), .addr_reg(addr_reg), .data_reg(data_reg)
   );

   epp_pin_mux #(.DATA_W(DATA_W)) u_mux (
      .in_cycle(in_cycle), .strobe_on(strobe_on), .kind(kind),
      .host_wr(host_wr), .host_wdata(host_wdata), .hold_q(hold_q),
      .ctl_strobe(ctl_strobe), .ctl_autofd(ctl_autofd), .ctl_selin(ctl_selin),
      .ctl_init(ctl_init), .ctl_dir(ctl_dir), .spp_data(spp_data),
      .pd_out(pd_out), .pd_oe(pd_oe), .write_n(write_n),
      .dstb_n(dstb_n), .astb_n(astb_n), .init_n(init_n)
   );

   assign host_rdata = hit_addr ? addr_reg : (hit_data ? data_reg : '0);
endmodule

// File: rtl/epp_cycle_checker.sv
module epp_cycle_checker (
   input logic clk,
   input logic rst_n,
   input logic epp_en,
   input logic in_cycle,
   input logic host_busy,
   input logic astb_n,
   input logic dstb_n,
   input logic write_n,
   input logic pd_oe,
   input logic periph_wait
);
   // R2 / R3: a transfer never drives both strobes at once
   assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_cycle |-> (astb_n || dstb_n));

   // R8: a transfer only begins while enhanced mode is enabled
   assert_start_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_cycle) |-> $past(epp_en));

   // R4 / R10: the write line does not move inside a transfer
   assert_write_line_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cycle && $past(in_cycle)) |-> $stable(write_n));

   // R10: a read transfer never drives the bus
   assert_read_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cycle && write_n) |-> !pd_oe);

   // R7: the data strobe is released only after wait was high
   assert_dstb_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cycle && $past(in_cycle) && $rose(dstb_n)) |-> $past(periph_wait));

   // R7: the address strobe is released only after wait was high
   assert_astb_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cycle && $past(in_cycle) && $rose(astb_n)) |-> $past(periph_wait));

   // R7: busy ends only after wait has gone low
   assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_busy) |-> !$past(periph_wait));
endmodule

bind epp_cycle_engine epp_cycle_checker u_chk (
   .clk(clk), .rst_n(rst_n), .epp_en(epp_en), .in_cycle(in_cycle),
   .host_busy(host_busy), .astb_n(astb_n), .dstb_n(dstb_n),
   .write_n(write_n), .pd_oe(pd_oe), .periph_wait(periph_wait)
);

// File: tb/epp_cycle_engine_tb.sv
module epp_cycle_engine_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       epp_en = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic       ctl_strobe = 0, ctl_autofd = 0, ctl_selin = 0, ctl_init = 0, ctl_dir = 0;
   logic [7:0] spp_data = 8'h5A;
   logic [7:0] pd_in;
   logic       periph_wait = 1'b0;
   logic [7:0] host_rdata, pd_out;
   logic       host_busy, pd_oe, write_n, dstb_n, astb_n, init_n;

   logic [7:0] rd_val = 8'h00;
   int         resp_delay = 0;
   int         low_run = 0;
   int         n_checks = 0, n_fail = 0;
   logic [7:0] exp_addr = 8'h00, exp_data = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   epp_cycle_engine u_dut (
      .clk(clk), .rst_n(rst_n), .epp_en(epp_en), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
      .host_rdata(host_rdata), .host_busy(host_busy),
      .ctl_strobe(ctl_strobe), .ctl_autofd(ctl_autofd), .ctl_selin(ctl_selin),
      .ctl_init(ctl_init), .ctl_dir(ctl_dir), .spp_data(spp_data),
      .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe), .write_n(write_n),
      .dstb_n(dstb_n), .astb_n(astb_n), .init_n(init_n), .periph_wait(periph_wait)
   );

   // peripheral model: wait rises resp_delay cycles after a strobe falls
   wire strobe_low = !astb_n || !dstb_n;
   assign pd_in = strobe_low ? rd_val : 8'hEE;
   always @(posedge clk) begin
      if (strobe_low) low_run <= low_run + 1; else low_run <= 0;
      periph_wait <= strobe_low && (low_run >= resp_delay);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
   end

   task automatic check_regs(input string req);
      logic [2:0] save = host_addr;
      logic       save_en = epp_en;
      epp_en = 1'b1;
      host_addr = 3'd3; #1;
      chk(host_rdata == exp_addr, req, host_rdata, exp_addr);
      for (int a = 4; a < 8; a++) begin
         host_addr = 3'(a); #1;
         chk(host_rdata == exp_data, req, host_rdata, exp_data);
      end
      host_addr = save; epp_en = save_en; #1;
   endtask

   task automatic do_access(input logic [2:0] ofs, input logic [7:0] d, input bit is_wr);
      bit hit = epp_en && (ofs >= 3);
      int seen_busy = 0, lowc = 0;
      bit bad_bus = 0, bad_wn = 0, bad_stb = 0, wait_at_end = 0;
      @(negedge clk);
      host_addr = ofs;
      if (is_wr) begin host_wdata = d; host_wr = 1'b1; end
      else begin rd_val = d; host_rd = 1'b1; end
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (host_busy) seen_busy++;
         if (hit) begin
            if (is_wr && (pd_out != d || !pd_oe)) bad_bus = 1;
            if (!is_wr && pd_oe) bad_bus = 1;
            if (write_n != !is_wr) bad_wn = 1;
            if (ofs == 3 ? !dstb_n : !astb_n) bad_stb = 1;
            if (ofs == 3 ? !astb_n : !dstb_n) lowc++;
            if (seen_busy > 0 && !host_busy) begin wait_at_end = periph_wait; break; end
         end else if (k == 8) break;
      end
      if (hit) begin
         chk(seen_busy > 0, "R7 busy raised", seen_busy, 1);
         chk(lowc > resp_delay, "R7 strobe held until wait", lowc, resp_delay + 1);
         chk(!wait_at_end, "R7 busy ends after wait low", wait_at_end, 0);
         chk(!bad_stb, ofs == 3 ? "R2 address strobe only" : "R3 data strobe only", bad_stb, 0);
         if (is_wr) begin
            chk(!bad_bus, "R4 bus carries host data", pd_out, d);
            chk(!bad_wn, "R4 write line low", write_n, 0);
         end else begin
            chk(!bad_bus, "R10 bus not driven on read", pd_oe, 0);
            chk(!bad_wn, "R10 write line high on read", write_n, 1);
            chk(host_rdata == d, "R6 read captured", host_rdata, d);
         end
      end else begin
         chk(seen_busy == 0, "R8 no transfer", seen_busy, 0);
      end
      @(negedge clk);
      if (is_wr) begin host_wr = 1'b0; host_wdata = ~d; end
      else host_rd = 1'b0;
      if (hit) begin
         if (ofs == 3) exp_addr = d; else exp_data = d;
      end
      repeat (2) @(negedge clk);
      if (!is_wr && hit) chk(pd_in == 8'hEE, "R6 bus moved after capture", pd_in, 8'hEE);
      check_regs(is_wr ? (hit ? "R5 trailing-edge value stored" : "R8 registers unchanged")
                       : (hit ? "R6 read value held" : "R8 registers unchanged"));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1
      chk(host_busy == 0, "R1 busy after reset", host_busy, 0);
      chk(astb_n && dstb_n && write_n, "R1 idle pins", {astb_n, dstb_n, write_n}, 7);
      check_regs("R1 registers cleared");

      // R9: idle fallback, all control combinations
      for (int c = 0; c < 32; c++) begin
         @(negedge clk);
         {ctl_strobe, ctl_autofd, ctl_selin, ctl_init, ctl_dir} = 5'(c);
         spp_data = 8'(c * 7 + 3);
         #1;
         chk({write_n, dstb_n, astb_n, init_n, pd_oe} == ~5'(c), "R9 pin fallback",
             {write_n, dstb_n, astb_n, init_n, pd_oe}, ~5'(c));
         chk(pd_out == 8'(c * 7 + 3), "R9 bus fallback", pd_out, 8'(c * 7 + 3));
      end
      @(negedge clk);
      {ctl_strobe, ctl_autofd, ctl_selin, ctl_init, ctl_dir} = '0;

      // writes over every offset and several peripheral delays
      epp_en = 1'b1;
      for (int dl = 0; dl < 3; dl++) begin
         resp_delay = dl;
         for (int o = 0; o < 8; o++)
            do_access(3'(o), 8'(o * 29 + dl * 5 + 1), 1'b1);
      end

      // R8: mode disabled
      epp_en = 1'b0;
      do_access(3'd3, 8'hC3, 1'b1);
      do_access(3'd6, 8'h3C, 1'b1);
      do_access(3'd4, 8'h99, 1'b0);
      epp_en = 1'b1;

      // reads over the responding offsets
      for (int dl = 0; dl < 2; dl++) begin
         resp_delay = dl * 2;
         for (int o = 2; o < 8; o++)
            do_access(3'(o), 8'(o * 41 + dl * 13 + 7), 1'b0);
      end

      finish_run();
   end
endmodule